// File: doc/BRIEF.md
# Link Training Supervisor

This block runs the bring-up of a root port's link. After a start pulse it performs two read-modify-write accesses on the port's configuration space. The first opens the subordinate bus number to 255. The second limits the advertised maximum speed to the first generation. Only after both writes does it raise the enable of the link state machine.

It then polls the link at a fixed interval. At each poll it reads two debug status words and, through a PHY register access port, the receiver-valid status. A link that is not up, with receiver-valid low and the link state code showing the recovery receiver-lock state, has a stuck speed change. The block recovers from it with an override pulse on the PHY receiver: it sets two override bits, holds them, then clears them again.

The block ends in one of two sticky outcomes: link up, or failure after a bounded number of polls. All time intervals are cycle-count parameters, so a simulation can shrink them.

Top module: `link_train_sup`

## Requirements
- R1: Out of reset the block is idle: `ltssm_en`, `link_up`, `fail`, `cfg_req` and `phy_req` are all low.
- R2: After `start`, the block reads configuration word 0x18 and writes it back with bits 23:16 set to 0xFF and all other bits unchanged.
- R3: Next, the block reads configuration word 0x7C and writes it back with bits 3:0 set to 1 and all other bits unchanged. Both writes complete while `ltssm_en` is low, and `ltssm_en` rises only after the second write.
- R4: The link counts as up only when `dbg1` bit 4 is 1 and `dbg1` bit 29 is 0. When a poll finds it up, `link_up` sets and stays set, and no further PHY or configuration access is made.
- R5: Every poll that finds the link not up reads PHY register 0x100D. Only bit 0 of the returned data is taken as receiver-valid.
- R6: A poll is stuck when receiver-valid is 0 and `dbg0` bits 5:0 equal 0x0D. For a stuck poll the block performs four PHY accesses in order. It reads register 0x1005, then writes it back with bits 5 and 3 set. It holds for exactly HOLD_CYCLES cycles, so the next read is accepted HOLD_CYCLES+1 cycles after the set write. It then reads 0x1005 again and writes it back with bits 5 and 3 cleared. The other bits pass through unchanged.
- R7: A poll that is not stuck (receiver-valid 1, or a state code other than 0x0D) makes no access to PHY register 0x1005.
- R8: Consecutive non-stuck polls are accepted POLL_CYCLES+3 cycles apart. No poll starts while a recovery pulse is in progress.
- R9: After MAX_POLLS polls without link-up, `fail` sets and stays set, `link_up` stays low, `ltssm_en` stays high, and all access stops.
- R10: A configuration or PHY request keeps its direction, address and write data stable until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins bring-up when idle |
| dbg0 | input | 32 | Debug status word 0; bits 5:0 hold the link state code |
| dbg1 | input | 32 | Debug status word 1; bit 4 up, bit 29 in training |
| cfg_req | output | 1 | Configuration access request |
| cfg_wr | output | 1 | Configuration access is a write |
| cfg_addr | output | 12 | Configuration byte address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_ack` |
| cfg_ack | input | 1 | Configuration access complete |
| phy_req | output | 1 | PHY register access request |
| phy_wr | output | 1 | PHY access is a write |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ack` |
| phy_ack | input | 1 | PHY access complete |
| ltssm_en | output | 1 | Enable for the link state machine |
| link_up | output | 1 | Sticky: link came up |
| fail | output | 1 | Sticky: poll budget exhausted |

## Verification
A corrupted sequencer state shows up at the access ports within one access. It appears as an out-of-order address, a write value whose preserved bits differ from what was read, or `ltssm_en` rising before both configuration writes. A wrong interval timer or poll counter shows up as a gap between acknowledged accesses that differs from the parameter by even one cycle. It also shows as a number of receiver-valid reads that differs from the link's modelled up point or from the poll budget when `link_up` or `fail` appears. A bad stuck decode shows up at the first poll as missing or extra accesses to the override register.

// File: rtl/ltsup_pkg.sv
package ltsup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_BUS,
        S_WR_BUS,
        S_RD_CAP,
        S_WR_CAP,
        S_POLL,
        S_RXV_RD,
        S_EVAL,
        S_OVR_RD1,
        S_OVR_SET,
        S_OVR_HOLD,
        S_OVR_RD2,
        S_OVR_CLR,
        S_GAP,
        S_UP,
        S_FAIL
    } ltsup_state_e;

    typedef struct packed {
        ltsup_state_e st;
        logic [31:0]  hold;
        logic         ltssm_en;
    } ltsup_regs_t;

    // configuration space word addresses
    localparam logic [11:0] CFG_BUS_ADDR = 12'h018;
    localparam logic [11:0] CFG_CAP_ADDR = 12'h07C;

    // PHY register addresses
    localparam logic [15:0] PHY_RXV_ADDR = 16'h100D;
    localparam logic [15:0] PHY_OVR_ADDR = 16'h1005;

endpackage

// File: rtl/ltsup_status_decode.sv
module ltsup_status_decode #(
    parameter int          UP_BIT     = 4,
    parameter int          TRAIN_BIT  = 29,
    parameter int          CODE_W     = 6,
    parameter logic [5:0]  STUCK_CODE = 6'h0D
) (
    input  logic [31:0] dbg0,
    input  logic [31:0] dbg1,
    input  logic        rx_valid,
    output logic        link_ok,
    output logic        stuck
);
    logic [CODE_W-1:0] code;
    logic              unused_dbg;

    assign code    = dbg0[CODE_W-1:0];
    assign link_ok = dbg1[UP_BIT] && !dbg1[TRAIN_BIT];
    assign stuck   = !rx_valid && (code == STUCK_CODE[CODE_W-1:0]);

    assign unused_dbg = ^{dbg0, dbg1};
endmodule

// File: rtl/ltsup_down_timer.sv
module ltsup_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ltsup_poll_counter.sv
module ltsup_poll_counter #(
    parameter int MAX_POLLS = 4000,
    parameter int W         = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == W'(MAX_POLLS - 1));
endmodule

// File: rtl/link_train_sup.sv
module link_train_sup #(
    parameter int          POLL_CYCLES = 1250,
    parameter int          HOLD_CYCLES = 375000,
    parameter int          MAX_POLLS   = 4000,
    parameter int          SUB_LSB     = 16,
    parameter logic [7:0]  SUB_VAL     = 8'hFF,
    parameter logic [3:0]  SPEED_VAL   = 4'h1,
    parameter int          OVR_DATA_BIT = 5,
    parameter int          OVR_PLL_BIT  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] dbg0,
    input  logic [31:0] dbg1,
    output logic        cfg_req,
    output logic        cfg_wr,
    output logic [11:0] cfg_addr,
    output logic [31:0] cfg_wdata,
    input  logic [31:0] cfg_rdata,
    input  logic        cfg_ack,
    output logic        phy_req,
    output logic        phy_wr,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic [15:0] phy_rdata,
    input  logic        phy_ack,
    output logic        ltssm_en,
    output logic        link_up,
    output logic        fail
);
    import ltsup_pkg::*;

    localparam int TMR_MAX = (HOLD_CYCLES > POLL_CYCLES) ? HOLD_CYCLES : POLL_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int PC_W    = $clog2(MAX_POLLS + 1);
    localparam logic [31:0] SUB_MASK = 32'h0000_00FF << SUB_LSB;
    localparam logic [31:0] SUB_SET  = 32'(SUB_VAL) << SUB_LSB;
    localparam logic [15:0] OVR_MASK = (16'h1 << OVR_DATA_BIT) | (16'h1 << OVR_PLL_BIT);

    ltsup_regs_t r_d, r_q;

    logic             link_ok, stuck;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             pc_clr, pc_inc, pc_last;

    ltsup_status_decode u_decode (
        .dbg0     (dbg0),
        .dbg1     (dbg1),
        .rx_valid (r_q.hold[0]),
        .link_ok  (link_ok),
        .stuck    (stuck)
    );

    ltsup_down_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ltsup_poll_counter #(.MAX_POLLS(MAX_POLLS), .W(PC_W)) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pc_clr),
        .inc   (pc_inc),
        .last  (pc_last)
    );

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = TMR_W'(POLL_CYCLES);
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        cfg_req   = 1'b0;
        cfg_wr    = 1'b0;
        cfg_addr  = CFG_BUS_ADDR;
        cfg_wdata = '0;
        phy_req   = 1'b0;
        phy_wr    = 1'b0;
        phy_addr  = PHY_RXV_ADDR;
        phy_wdata = '0;

        case (r_q.st)
            S_IDLE: begin
                pc_clr = 1'b1;
                if (start) r_d.st = S_RD_BUS;
            end
            S_RD_BUS: begin
                cfg_req  = 1'b1;
                cfg_addr = CFG_BUS_ADDR;
                if (cfg_ack) begin
                    r_d.hold = cfg_rdata;
                    r_d.st   = S_WR_BUS;
                end
            end
            S_WR_BUS: begin
                cfg_req   = 1'b1;
                cfg_wr    = 1'b1;
                cfg_addr  = CFG_BUS_ADDR;
                cfg_wdata = (r_q.hold & ~SUB_MASK) | SUB_SET;
                if (cfg_ack) r_d.st = S_RD_CAP;
            end
            S_RD_CAP: begin
                cfg_req  = 1'b1;
                cfg_addr = CFG_CAP_ADDR;
                if (cfg_ack) begin
                    r_d.hold = cfg_rdata;
                    r_d.st   = S_WR_CAP;
                end
            end
            S_WR_CAP: begin
                cfg_req   = 1'b1;
                cfg_wr    = 1'b1;
                cfg_addr  = CFG_CAP_ADDR;
                cfg_wdata = {r_q.hold[31:4], SPEED_VAL};
                if (cfg_ack) begin
                    r_d.ltssm_en = 1'b1;
                    r_d.st       = S_POLL;
                end
            end
            S_POLL: begin
                if (link_ok) r_d.st = S_UP;
                else         r_d.st = S_RXV_RD;
            end
            S_RXV_RD: begin
                phy_req  = 1'b1;
                phy_addr = PHY_RXV_ADDR;
                if (phy_ack) begin
                    r_d.hold = 32'(phy_rdata);
                    r_d.st   = S_EVAL;
                end
            end
            S_EVAL: begin
                if (stuck) begin
                    r_d.st = S_OVR_RD1;
                end else begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(POLL_CYCLES);
                    r_d.st   = S_GAP;
                end
            end
            S_OVR_RD1: begin
                phy_req  = 1'b1;
                phy_addr = PHY_OVR_ADDR;
                if (phy_ack) begin
                    r_d.hold = 32'(phy_rdata);
                    r_d.st   = S_OVR_SET;
                end
            end
            S_OVR_SET: begin
                phy_req   = 1'b1;
                phy_wr    = 1'b1;
                phy_addr  = PHY_OVR_ADDR;
                phy_wdata = r_q.hold[15:0] | OVR_MASK;
                if (phy_ack) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(HOLD_CYCLES);
                    r_d.st   = S_OVR_HOLD;
                end
            end
            S_OVR_HOLD: begin
                if (tmr_zero) r_d.st = S_OVR_RD2;
            end
            S_OVR_RD2: begin
                phy_req  = 1'b1;
                phy_addr = PHY_OVR_ADDR;
                if (phy_ack) begin
                    r_d.hold = 32'(phy_rdata);
                    r_d.st   = S_OVR_CLR;
                end
            end
            S_OVR_CLR: begin
                phy_req   = 1'b1;
                phy_wr    = 1'b1;
                phy_addr  = PHY_OVR_ADDR;
                phy_wdata = r_q.hold[15:0] & ~OVR_MASK;
                if (phy_ack) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(POLL_CYCLES);
                    r_d.st   = S_GAP;
                end
            end
            S_GAP: begin
                if (tmr_zero) begin
                    if (pc_last) begin
                        r_d.st = S_FAIL;
                    end else begin
                        pc_inc = 1'b1;
                        r_d.st = S_POLL;
                    end
                end
            end
            S_UP:    r_d.st = S_UP;
            S_FAIL:  r_d.st = S_FAIL;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= S_IDLE;
            r_q.hold     <= '0;
            r_q.ltssm_en <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ltssm_en = r_q.ltssm_en;
    assign link_up  = (r_q.st == S_UP);
    assign fail     = (r_q.st == S_FAIL);

endmodule

// File: rtl/ltsup_checker.sv
module ltsup_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_req,
    input logic        cfg_wr,
    input logic [11:0] cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        cfg_ack,
    input logic        phy_req,
    input logic        phy_wr,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic [15:0] phy_rdata,
    input logic        phy_ack,
    input logic        ltssm_en,
    input logic        link_up,
    input logic        fail
);
    import ltsup_pkg::*;

    logic [1:0] cfg_wr_seen;
    logic       rxv_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_wr_seen <= '0;
            rxv_seen    <= 1'b1;
        end else begin
            if (cfg_req && cfg_wr && cfg_ack && cfg_wr_seen != 2'd3)
                cfg_wr_seen <= cfg_wr_seen + 2'd1;
            if (phy_req && !phy_wr && phy_ack && phy_addr == PHY_RXV_ADDR)
                rxv_seen <= phy_rdata[0];
        end
    end

    AST_IDLE_AT_RESET: assert property (@(posedge clk)
        !rst_n |-> !ltssm_en && !link_up && !fail && !cfg_req && !phy_req); // R1

    AST_EN_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en |-> cfg_wr_seen >= 2'd2); // R3

    AST_NO_CFG_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en |-> !cfg_req); // R3

    AST_UP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> link_up); // R4

    AST_QUIET_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up || fail) |-> !phy_req && !cfg_req); // R4

    AST_OVR_ONLY_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_addr == PHY_OVR_ADDR) |-> !rxv_seen); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail && ltssm_en); // R9

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail && link_up)); // R9

    AST_PHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> phy_req && $stable(phy_wr) && $stable(phy_addr) && $stable(phy_wdata)); // R10

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> cfg_req && $stable(cfg_wr) && $stable(cfg_addr) && $stable(cfg_wdata)); // R10

endmodule

bind link_train_sup ltsup_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_req   (cfg_req),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .phy_req   (phy_req),
    .phy_wr    (phy_wr),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_rdata (phy_rdata),
    .phy_ack   (phy_ack),
    .ltssm_en  (ltssm_en),
    .link_up   (link_up),
    .fail      (fail)
);

// File: tb/link_train_sup_tb.sv
module link_train_sup_tb;

    localparam int POLL = 8;
    localparam int HOLD = 20;
    localparam int MAXP = 6;
    localparam int LOGN = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dbg0 = '0;
    logic [31:0] dbg1 = '0;
    logic        cfg_req, cfg_wr;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;
    logic        cfg_ack = 1'b0;
    logic        phy_req, phy_wr;
    logic [15:0] phy_addr, phy_wdata;
    logic [15:0] phy_rdata = '0;
    logic        phy_ack = 1'b0;
    logic        ltssm_en, link_up, fail;

    always #4 clk = ~clk;

    link_train_sup #(
        .POLL_CYCLES (POLL),
        .HOLD_CYCLES (HOLD),
        .MAX_POLLS   (MAXP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .dbg0 (dbg0), .dbg1 (dbg1),
        .cfg_req (cfg_req), .cfg_wr (cfg_wr), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .cfg_ack (cfg_ack),
        .phy_req (phy_req), .phy_wr (phy_wr), .phy_addr (phy_addr),
        .phy_wdata (phy_wdata), .phy_rdata (phy_rdata), .phy_ack (phy_ack),
        .ltssm_en (ltssm_en), .link_up (link_up), .fail (fail)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    always @(posedge clk) cyc++;

    // link and register model
    logic [31:0] m_bus, m_cap, d1_noise;
    logic [15:0] m_ovr;
    logic        rxv_bit, use_train;
    int          up_after, rx_reads;

    // access logs
    logic        op_wr   [0:LOGN-1];
    logic [15:0] op_addr [0:LOGN-1];
    logic [15:0] op_data [0:LOGN-1];
    int          op_cyc  [0:LOGN-1];
    int          n_ops;
    logic [11:0] cw_addr [0:3];
    logic [31:0] cw_data [0:3];
    logic        cw_en   [0:3];
    int          n_cw;

    function automatic logic [31:0] mk_dbg1(input logic up, input logic tr, input logic [31:0] noise);
        logic [31:0] v;
        v = noise & ~32'h2000_0010;
        if (tr) v = v | 32'h0000_0010 | (up ? 32'h0 : 32'h2000_0000);
        else    v = v | (up ? 32'h0000_0010 : 32'h0);
        return v;
    endfunction

    function automatic logic [31:0] exp_bus(input logic [31:0] v);
        return (v & ~32'h00FF_0000) | 32'h00FF_0000;
    endfunction

    function automatic logic [31:0] exp_cap(input logic [31:0] v);
        return (v & ~32'h0000_000F) | 32'h0000_0001;
    endfunction

    // configuration space model
    always @(negedge clk) begin
        if (cfg_req && !cfg_ack) begin
            cfg_ack = 1'b1;
            if (cfg_wr) begin
                if (n_cw < 4) begin
                    cw_addr[n_cw] = cfg_addr;
                    cw_data[n_cw] = cfg_wdata;
                    cw_en[n_cw]   = ltssm_en;
                end
                n_cw++;
                if (cfg_addr == 12'h018) m_bus = cfg_wdata;
                if (cfg_addr == 12'h07C) m_cap = cfg_wdata;
            end else begin
                cfg_rdata = (cfg_addr == 12'h018) ? m_bus :
                            (cfg_addr == 12'h07C) ? m_cap : 32'hDEAD_BEEF;
            end
        end else begin
            cfg_ack = 1'b0;
        end
    end

    // PHY register model
    always @(negedge clk) begin
        if (phy_req && !phy_ack) begin
            phy_ack = 1'b1;
            if (n_ops < LOGN) begin
                op_wr[n_ops]   = phy_wr;
                op_addr[n_ops] = phy_addr;
                op_data[n_ops] = phy_wdata;
                op_cyc[n_ops]  = cyc;
            end
            n_ops++;
            if (phy_wr) begin
                if (phy_addr == 16'h1005) m_ovr = phy_wdata;
            end else if (phy_addr == 16'h100D) begin
                phy_rdata = {d1_noise[31:17], rxv_bit};
                rx_reads++;
                dbg1 = mk_dbg1(rx_reads >= up_after, use_train, d1_noise);
            end else begin
                phy_rdata = (phy_addr == 16'h1005) ? m_ovr : 16'hBAD0;
            end
        end else begin
            phy_ack = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic run_case(input int ua, input logic tr, input logic [5:0] code,
                            input logic rv, input logic exp_fail);
        logic [31:0] b0, c0;
        logic [15:0] v;
        logic        is_stuck;
        int          k, n0, base;
        is_stuck  = !exp_fail ? 1'b0 : (!rv && code == 6'h0D);
        up_after  = ua;
        use_train = tr;
        rxv_bit   = rv;
        m_bus     = $urandom;
        m_cap     = $urandom;
        m_ovr     = 16'($urandom);
        d1_noise  = $urandom;
        b0 = m_bus;
        c0 = m_cap;
        v  = m_ovr;
        rx_reads = 0;
        n_ops = 0;
        n_cw  = 0;
        dbg0 = ($urandom & ~32'h3F) | 32'(code);
        dbg1 = mk_dbg1(ua == 0, tr, d1_noise);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {27'h0, ltssm_en, link_up, fail, cfg_req, phy_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!(link_up || fail) && k < 8000) begin
            @(negedge clk);
            k++;
        end
        chk("R4/R9 case finished", 32'(k < 8000), 32'h1);

        chk("R2 bus write address", 32'(cw_addr[0]), 32'h018);
        chk("R2 bus write data", cw_data[0], exp_bus(b0));
        chk("R3 cap write address", 32'(cw_addr[1]), 32'h07C);
        chk("R3 cap write data", cw_data[1], exp_cap(c0));
        chk("R3 enable low during writes", {30'h0, cw_en[0], cw_en[1]}, 32'h0);
        chk("R3 enable high after writes", 32'(ltssm_en), 32'h1);
        chk("R4 link_up", 32'(link_up), 32'(!exp_fail));
        chk("R9 fail", 32'(fail), 32'(exp_fail));
        chk("R5 receiver-valid reads", 32'(rx_reads), exp_fail ? 32'(MAXP) : 32'(ua));

        if (is_stuck) begin
            chk("R6 op count", 32'(n_ops), 32'(5 * MAXP));
            for (int p = 0; p < MAXP; p++) begin
                base = 5 * p;
                chk("R5 poll read", {15'h0, op_wr[base], op_addr[base]}, 32'h0000_100D);
                chk("R6 override read 1", {15'h0, op_wr[base+1], op_addr[base+1]}, 32'h0000_1005);
                chk("R6 override set", {op_wr[base+2], op_addr[base+2], op_data[base+2][14:0]},
                    {1'b1, 16'h1005, 15'(v | 16'h0028)});
                chk("R6 set data top bit", 32'(op_data[base+2][15]), 32'(v[15]));
                v = v | 16'h0028;
                chk("R6 hold gap", 32'(op_cyc[base+3] - op_cyc[base+2]), 32'(HOLD + 1));
                chk("R6 override read 2", {15'h0, op_wr[base+3], op_addr[base+3]}, 32'h0000_1005);
                chk("R6 override clear", {16'h0, op_data[base+4]}, {16'h0, v & ~16'h0028});
                chk("R6 clear is write", {15'h0, op_wr[base+4], op_addr[base+4]}, 32'h0001_1005);
                v = v & ~16'h0028;
            end
        end else begin
            chk("R7 only receiver-valid reads", 32'(n_ops), 32'(rx_reads));
            for (int i = 0; i < n_ops && i < LOGN; i++) begin
                if (op_addr[i] != 16'h100D || op_wr[i]) begin
                    chk("R7 unexpected PHY access", {15'h0, op_wr[i], op_addr[i]}, 32'h0000_100D);
                end
                if (i > 0) chk("R8 poll spacing", 32'(op_cyc[i] - op_cyc[i-1]), 32'(POLL + 3));
            end
        end

        n0 = n_ops;
        repeat (40) @(negedge clk);
        chk("R4/R9 no access after outcome", 32'(n_ops), 32'(n0));
        chk("R4/R9 outcome held", {29'h0, ltssm_en, link_up, fail}, {29'h0, 1'b1, !exp_fail, exp_fail});
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_bus = '0; m_cap = '0; m_ovr = '0; d1_noise = '0;
        rxv_bit = 1'b1; use_train = 1'b0; up_after = 0; rx_reads = 0;
        n_ops = 0; n_cw = 0;

        // directed corners
        run_case(0,        1'b0, 6'h11, 1'b1, 1'b0); // R4 up at first poll
        run_case(3,        1'b0, 6'h11, 1'b1, 1'b0); // R5 R8 up after three polls
        run_case(MAXP - 1, 1'b1, 6'h0D, 1'b1, 1'b0); // R7 state 0x0D, receiver valid
        run_case(2,        1'b0, 6'h0C, 1'b0, 1'b0); // R7 receiver invalid, other state
        run_case(1000,     1'b0, 6'h0D, 1'b0, 1'b1); // R6 R9 stuck until budget runs out
        run_case(1000,     1'b1, 6'h11, 1'b1, 1'b1); // R4 R9 up bit with training never clear

        // constrained random non-stuck bring-ups
        for (int t = 0; t < 6; t++) begin
            logic [5:0] c;
            logic       rv;
            c  = 6'($urandom);
            rv = 1'($urandom);
            if (c == 6'h0D) rv = 1'b1;
            run_case($urandom_range(0, MAXP - 1), 1'($urandom), c, rv, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule